// File: doc/BRIEF.md
# Pipeline Hazard Control

This block is the combinational stall and flush controller for a five-stage in-order pipeline with fetch, decode, execute, memory and writeback stages. It looks at the instruction in decode, the instruction in execute and the access in the memory stage. From these it decides, in the same cycle, whether the program counter and the fetch/decode register may advance. It also decides whether the control fields entering the decode/execute register are replaced by a no-op bubble, and whether the fetch/decode register is loaded with a no-op.

It handles three conditions:

- **Load-use stall.** A load in execute writes a register that the decoding instruction reads. The controller holds the front of the pipe for one cycle and lets a bubble through.
- **Shared-memory conflict.** Instructions and data share one single-port memory. When the memory stage reads or writes, no fetch can happen that cycle, so the PC is held and a no-op enters fetch/decode while decode keeps moving.
- **Taken branch.** A branch resolved taken in execute lets the PC load its target. The two younger instructions are squashed.

Operand forwarding is handled elsewhere.

Top module: `pipe_hazard_unit`

## Requirements
- R1: When execute holds a load (ex_load_i=1) whose destination equals a source register that decode reads, and no branch is taken, the outputs are pc_we_o=0, ifid_we_o=0, ifid_nop_o=0, idex_nop_o=1.
- R2: A load destination of register 0 never causes a load-use stall, even if it matches a decode source.
- R3: A source register flagged as unused (id_rs1_use_i=0 or id_rs2_use_i=0) is left out of the comparison.
- R4: An instruction in execute that is not a load (ex_load_i=0) never causes a load-use stall.
- R5: When the memory stage reads or writes (mem_rd_i or mem_wr_i is 1), and there is no branch and no load-use stall, the outputs are pc_we_o=0, ifid_we_o=1, ifid_nop_o=1, idex_nop_o=0.
- R6: A load-use stall takes priority over a shared-memory conflict raised in the same cycle; the outputs are those of R1.
- R7: A taken branch (ex_br_taken_i=1) gives pc_we_o=1, ifid_we_o=1, ifid_nop_o=1, idex_nop_o=1.
- R8: A taken branch takes priority over a load-use stall and a memory conflict in the same cycle; the outputs are those of R7.
- R9: With no hazard present, the outputs are pc_we_o=1, ifid_we_o=1, ifid_nop_o=0, idex_nop_o=0.
- R10: The outputs depend only on the current inputs and hold no state, so a stall lasts exactly as long as its cause is present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| id_rs1_i | input | REG_AW | First source register of the instruction in decode |
| id_rs2_i | input | REG_AW | Second source register of the instruction in decode |
| id_rs1_use_i | input | 1 | Decode instruction reads its first source |
| id_rs2_use_i | input | 1 | Decode instruction reads its second source |
| ex_rd_i | input | REG_AW | Destination register of the instruction in execute |
| ex_load_i | input | 1 | Instruction in execute is a load |
| mem_rd_i | input | 1 | Memory stage reads the shared memory |
| mem_wr_i | input | 1 | Memory stage writes the shared memory |
| ex_br_taken_i | input | 1 | Branch in execute is resolved taken |
| pc_we_o | output | 1 | Program counter write enable |
| ifid_we_o | output | 1 | Fetch/decode register write enable |
| ifid_nop_o | output | 1 | Load a no-op into the fetch/decode register |
| idex_nop_o | output | 1 | Zero the control fields entering decode/execute |

## Verification
Every result is combinational, so each output is due in the same cycle its inputs are applied; no register lies on any path. The bench drives a full input vector just after a falling clock edge and samples one nanosecond later, well before the next rising edge. It then changes the inputs back and checks again, so any hidden state shows up as a stale output. Priority cases apply two or three causes in one vector and compare all four outputs at once.

// File: rtl/hdu_pkg.sv
package hdu_pkg;
  typedef enum logic [1:0] {
    HZ_NONE   = 2'd0,
    HZ_MEM    = 2'd1,
    HZ_LOAD   = 2'd2,
    HZ_BRANCH = 2'd3
  } hz_cause_e;

  typedef struct packed {
    logic pc_we;
    logic ifid_we;
    logic ifid_nop;
    logic idex_nop;
  } hz_ctrl_t;

  localparam int unsigned NUM_SRC = 2;
endpackage

// File: rtl/hdu_load_use.sv
module hdu_load_use
  import hdu_pkg::*;
#(
  parameter int unsigned REG_AW = 5
) (
  input  logic [NUM_SRC-1:0][REG_AW-1:0] src_i,
  input  logic [NUM_SRC-1:0]             src_use_i,
  input  logic [REG_AW-1:0]              ld_rd_i,
  input  logic                           ld_i,
  output logic                           hit_o
);
  localparam logic [REG_AW-1:0] ZERO_REG = '0;

  logic [NUM_SRC-1:0] match;
  logic               rd_live;

  assign rd_live = ld_i && (ld_rd_i != ZERO_REG);

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    assign match[s] = src_use_i[s] && (src_i[s] == ld_rd_i);
  end

  assign hit_o = rd_live && (|match);
endmodule

// File: rtl/hdu_mem_conflict.sv
module hdu_mem_conflict (
  input  logic mem_rd_i,
  input  logic mem_wr_i,
  output logic busy_o
);
  // single port: any data access steals the fetch slot
  assign busy_o = mem_rd_i | mem_wr_i;
endmodule

// File: rtl/hdu_arbiter.sv
module hdu_arbiter
  import hdu_pkg::*;
(
  input  logic     br_i,
  input  logic     ld_hit_i,
  input  logic     mem_busy_i,
  output hz_ctrl_t ctrl_o
);
  hz_cause_e cause;

  always_comb begin
    if (br_i)            cause = HZ_BRANCH;
    else if (ld_hit_i)   cause = HZ_LOAD;
    else if (mem_busy_i) cause = HZ_MEM;
    else                 cause = HZ_NONE;
  end

  always_comb begin
    unique case (cause)
      HZ_BRANCH: ctrl_o = '{pc_we: 1'b1, ifid_we: 1'b1, ifid_nop: 1'b1, idex_nop: 1'b1};
      HZ_LOAD:   ctrl_o = '{pc_we: 1'b0, ifid_we: 1'b0, ifid_nop: 1'b0, idex_nop: 1'b1};
      HZ_MEM:    ctrl_o = '{pc_we: 1'b0, ifid_we: 1'b1, ifid_nop: 1'b1, idex_nop: 1'b0};
      default:   ctrl_o = '{pc_we: 1'b1, ifid_we: 1'b1, ifid_nop: 1'b0, idex_nop: 1'b0};
    endcase
  end
endmodule

// File: rtl/pipe_hazard_unit.sv
module pipe_hazard_unit
  import hdu_pkg::*;
#(
  parameter int unsigned REG_AW = 5
) (
  input  logic [REG_AW-1:0] id_rs1_i,
  input  logic [REG_AW-1:0] id_rs2_i,
  input  logic              id_rs1_use_i,
  input  logic              id_rs2_use_i,
  input  logic [REG_AW-1:0] ex_rd_i,
  input  logic              ex_load_i,
  input  logic              mem_rd_i,
  input  logic              mem_wr_i,
  input  logic              ex_br_taken_i,
  output logic              pc_we_o,
  output logic              ifid_we_o,
  output logic              ifid_nop_o,
  output logic              idex_nop_o
);
  logic [NUM_SRC-1:0][REG_AW-1:0] src;
  logic [NUM_SRC-1:0]             src_use;
  logic                           ld_hit;
  logic                           mem_busy;
  hz_ctrl_t                       ctrl;

  assign src     = {id_rs2_i, id_rs1_i};
  assign src_use = {id_rs2_use_i, id_rs1_use_i};

  hdu_load_use #(.REG_AW(REG_AW)) u_load_use (
    .src_i     (src),
    .src_use_i (src_use),
    .ld_rd_i   (ex_rd_i),
    .ld_i      (ex_load_i),
    .hit_o     (ld_hit)
  );

  hdu_mem_conflict u_mem_conflict (
    .mem_rd_i (mem_rd_i),
    .mem_wr_i (mem_wr_i),
    .busy_o   (mem_busy)
  );

  hdu_arbiter u_arbiter (
    .br_i       (ex_br_taken_i),
    .ld_hit_i   (ld_hit),
    .mem_busy_i (mem_busy),
    .ctrl_o     (ctrl)
  );

  assign pc_we_o    = ctrl.pc_we;
  assign ifid_we_o  = ctrl.ifid_we;
  assign ifid_nop_o = ctrl.ifid_nop;
  assign idex_nop_o = ctrl.idex_nop;
endmodule

// File: rtl/pipe_hazard_unit_chk.sv
module pipe_hazard_unit_chk #(
  parameter int unsigned REG_AW = 5
) (
  input logic [REG_AW-1:0] id_rs1_i,
  input logic [REG_AW-1:0] id_rs2_i,
  input logic              id_rs1_use_i,
  input logic              id_rs2_use_i,
  input logic [REG_AW-1:0] ex_rd_i,
  input logic              ex_load_i,
  input logic              mem_rd_i,
  input logic              mem_wr_i,
  input logic              ex_br_taken_i,
  input logic              pc_we_o,
  input logic              ifid_we_o,
  input logic              ifid_nop_o,
  input logic              idex_nop_o
);
  logic known;
  assign known = !$isunknown({id_rs1_i, id_rs2_i, id_rs1_use_i, id_rs2_use_i, ex_rd_i,
                              ex_load_i, mem_rd_i, mem_wr_i, ex_br_taken_i});

  always_comb begin
    if (known) begin
      // R7
      branch_squash_chk: assert (!ex_br_taken_i || (pc_we_o && ifid_we_o && ifid_nop_o && idex_nop_o));
      // R1
      ld_freeze_chk: assert (ex_br_taken_i || !idex_nop_o || (!pc_we_o && !ifid_we_o && !ifid_nop_o));
      // R4
      no_load_no_bubble_chk: assert (ex_br_taken_i || ex_load_i || !idex_nop_o);
      // R2
      zero_rd_chk: assert (ex_br_taken_i || (ex_rd_i != '0) || !idex_nop_o);
      // R5
      mem_slot_chk: assert (ex_br_taken_i || idex_nop_o || !(mem_rd_i || mem_wr_i)
                            || (!pc_we_o && ifid_we_o && ifid_nop_o));
      // R9
      idle_chk: assert (ex_br_taken_i || ex_load_i || mem_rd_i || mem_wr_i
                        || (pc_we_o && ifid_we_o && !ifid_nop_o && !idex_nop_o));
    end
  end
endmodule

bind pipe_hazard_unit pipe_hazard_unit_chk #(.REG_AW(REG_AW)) u_chk (
  .id_rs1_i      (id_rs1_i),
  .id_rs2_i      (id_rs2_i),
  .id_rs1_use_i  (id_rs1_use_i),
  .id_rs2_use_i  (id_rs2_use_i),
  .ex_rd_i       (ex_rd_i),
  .ex_load_i     (ex_load_i),
  .mem_rd_i      (mem_rd_i),
  .mem_wr_i      (mem_wr_i),
  .ex_br_taken_i (ex_br_taken_i),
  .pc_we_o       (pc_we_o),
  .ifid_we_o     (ifid_we_o),
  .ifid_nop_o    (ifid_nop_o),
  .idex_nop_o    (idex_nop_o)
);

// File: tb/pipe_hazard_unit_bench.sv
module pipe_hazard_unit_bench;
  localparam int unsigned REG_AW = 5;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #5 clk = ~clk;

  logic [REG_AW-1:0] id_rs1, id_rs2, ex_rd;
  logic id_rs1_use, id_rs2_use, ex_load, mem_rd, mem_wr, br;
  logic pc_we, ifid_we, ifid_nop, idex_nop;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  pipe_hazard_unit #(.REG_AW(REG_AW)) u_pipe_hazard_unit (
    .id_rs1_i      (id_rs1),
    .id_rs2_i      (id_rs2),
    .id_rs1_use_i  (id_rs1_use),
    .id_rs2_use_i  (id_rs2_use),
    .ex_rd_i       (ex_rd),
    .ex_load_i     (ex_load),
    .mem_rd_i      (mem_rd),
    .mem_wr_i      (mem_wr),
    .ex_br_taken_i (br),
    .pc_we_o       (pc_we),
    .ifid_we_o     (ifid_we),
    .ifid_nop_o    (ifid_nop),
    .idex_nop_o    (idex_nop)
  );

  localparam logic [3:0] RUN   = 4'b1100;  // pc_we, ifid_we, ifid_nop, idex_nop
  localparam logic [3:0] LDST  = 4'b0001;
  localparam logic [3:0] MEMST = 4'b0110;
  localparam logic [3:0] BRST  = 4'b1111;

  task automatic apply(input logic [4:0] r1, input logic [4:0] r2, input logic u1,
                       input logic u2, input logic [4:0] rd, input logic ld,
                       input logic mr, input logic mw, input logic b);
    @(negedge clk);
    id_rs1 = r1; id_rs2 = r2; id_rs1_use = u1; id_rs2_use = u2;
    ex_rd = rd; ex_load = ld; mem_rd = mr; mem_wr = mw; br = b;
    #1;
  endtask

  task automatic expect_out(input string req, input logic [3:0] exp);
    logic [3:0] act;
    act = {pc_we, ifid_we, ifid_nop, idex_nop};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic t_idle();
    apply(5'd3, 5'd4, 1, 1, 5'd9, 0, 0, 0, 0);
    expect_out("R9", RUN);
  endtask

  task automatic t_load_use();
    apply(5'd7, 5'd2, 1, 1, 5'd7, 1, 0, 0, 0);
    expect_out("R1 rs1", LDST);
    apply(5'd1, 5'd12, 1, 1, 5'd12, 1, 0, 0, 0);
    expect_out("R1 rs2", LDST);
    // cause removed: no lingering stall
    apply(5'd1, 5'd12, 1, 1, 5'd13, 1, 0, 0, 0);
    expect_out("R10", RUN);
  endtask

  task automatic t_zero_reg();
    apply(5'd0, 5'd0, 1, 1, 5'd0, 1, 0, 0, 0);
    expect_out("R2", RUN);
  endtask

  task automatic t_unused_src();
    apply(5'd6, 5'd8, 0, 1, 5'd6, 1, 0, 0, 0);
    expect_out("R3 rs1", RUN);
    apply(5'd8, 5'd6, 1, 0, 5'd6, 1, 0, 0, 0);
    expect_out("R3 rs2", RUN);
  endtask

  task automatic t_non_load();
    apply(5'd5, 5'd5, 1, 1, 5'd5, 0, 0, 0, 0);
    expect_out("R4", RUN);
  endtask

  task automatic t_mem();
    apply(5'd3, 5'd4, 1, 1, 5'd9, 0, 1, 0, 0);
    expect_out("R5 read", MEMST);
    apply(5'd3, 5'd4, 1, 1, 5'd9, 0, 0, 1, 0);
    expect_out("R5 write", MEMST);
    apply(5'd3, 5'd4, 1, 1, 5'd9, 0, 0, 0, 0);
    expect_out("R10 mem release", RUN);
  endtask

  task automatic t_priority();
    apply(5'd11, 5'd4, 1, 1, 5'd11, 1, 1, 0, 0);
    expect_out("R6", LDST);
    apply(5'd3, 5'd4, 1, 1, 5'd9, 0, 0, 0, 1);
    expect_out("R7", BRST);
    apply(5'd11, 5'd4, 1, 1, 5'd11, 1, 0, 1, 1);
    expect_out("R8", BRST);
  endtask

  initial begin
    id_rs1 = '0; id_rs2 = '0; id_rs1_use = 0; id_rs2_use = 0;
    ex_rd = '0; ex_load = 0; mem_rd = 0; mem_wr = 0; br = 0;
    repeat (2) @(posedge clk);
    rst_ni = 1'b1;
    #1;
    expect_out("R9 reset", RUN);
    t_idle();
    t_load_use();
    t_zero_reg();
    t_unused_src();
    t_non_load();
    t_mem();
    t_priority();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule